// File: doc/BRIEF.md
# Early-Terminating Byte-Serial Multiplier

This block executes the register-to-register multiply of a 16-bit compressed instruction set. The caller presents an instruction halfword together with the current values of the two named registers and raises a start request. The block checks that the halfword really encodes the multiply. It then builds the low 32 bits of the product by walking the multiplier operand one byte per clock and adding one shifted partial product per step into an accumulator.

The walk stops after the highest non-zero byte of the multiplier operand. Small multipliers therefore finish in one cycle and full-width ones in four. When the walk ends, a one-cycle done pulse marks the result as valid and names the destination register that should take the write. A halfword that is not the multiply raises a one-cycle illegal flag instead, and nothing is written.

The source register index is decoded combinationally from the presented halfword, so a register file can read both operands in the same cycle as the request.

Top module: `early_exit_mul`

## Requirements
- R1: A halfword is accepted as the multiply exactly when `(instr_i & 16'hFFC0) == 16'h4340`. In that encoding bits 15:10 are 010000 and the opcode field in bits 9:6 is 1101.
- R2: A start with any other halfword raises `illegal_o` for exactly the cycle after the accepting edge. It never raises `busy_o` or `done_o`, and `result_o` and `rd_idx_o` keep their previous values.
- R3: `result_o` holds the low 32 bits of `rd_val_i * rs_val_i`, using the operand values sampled at the accepting edge. `rd_idx_o` is instr bits 2:0 captured at that edge. `src_idx_o` always equals `instr_i[5:3]`.
- R4: Counting clock edges from the accepting edge to the edge after which `done_o` is high, the latency is 1 when rs bits 31:8 are zero. It is 2 when bits 31:16 are zero but bits 15:8 are not, 3 when bits 31:24 are zero but bits 23:16 are not, and 4 otherwise.
- R5: The zero test looks at the raw bit pattern, so any rs with bit 31 set takes 4 cycles.
- R6: `busy_o` is high from the cycle after an accepted multiply up to, but not including, the done cycle. `ready_o` is always the inverse of `busy_o`.
- R7: `done_o` is a single-cycle pulse. `result_o` and `rd_idx_o` stay stable after it until the next accepted multiply.
- R8: A start request while `busy_o` is high is ignored and does not change the running result.
- R9: After the asynchronous reset, `busy_o`, `done_o`, `illegal_o`, `result_o` and `rd_idx_o` are all zero, and `ready_o` is high.
- R10: A start presented in the done cycle is accepted at the next edge, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to execute `instr_i` |
| ready_o | output | 1 | Block can accept a request |
| instr_i | input | 16 | Instruction halfword |
| rd_val_i | input | 32 | Value of the destination/first-operand register |
| rs_val_i | input | 32 | Value of the multiplier register |
| src_idx_o | output | 3 | Multiplier register index decoded from `instr_i` |
| result_o | output | 32 | Accumulated product |
| rd_idx_o | output | 3 | Destination register index for writeback |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | Result valid pulse |
| illegal_o | output | 1 | Rejected-halfword pulse |

## Verification
Two events can fall in the same cycle: the completion of one multiply (its done pulse with `ready_o` back high) and the acceptance of the next request. The bench provokes this by raising start during the very cycle it sees `done_o`. It confirms that the first result is read correctly in that cycle. It then confirms that the second operation runs with its own latency and product and that it is not delayed by an extra idle cycle. A second overlap, a new start arriving while a walk is in progress, is driven with different operands and an illegal halfword, and it is judged by the final result of the original operation.

// File: rtl/emul_pkg.sv
package emul_pkg;
  localparam int INSN_W    = 16;
  localparam int REG_IDX_W = 3;
  localparam logic [INSN_W-1:0] MUL_MASK  = 16'hFFC0;
  localparam logic [INSN_W-1:0] MUL_MATCH = 16'h4340;

  typedef struct packed {
    logic                 legal;
    logic [REG_IDX_W-1:0] src;
    logic [REG_IDX_W-1:0] dst;
  } dec_t;
endpackage

// File: rtl/emul_decode.sv
module emul_decode
  import emul_pkg::*;
(
  input  logic [INSN_W-1:0] instr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.legal = (instr_i & MUL_MASK) == MUL_MATCH;
    dec_o.dst   = instr_i[REG_IDX_W-1:0];
    dec_o.src   = instr_i[2*REG_IDX_W-1:REG_IDX_W];
  end
endmodule

// File: rtl/emul_span.sv
// Number of lanes up to and including the highest non-zero one (min 1).
module emul_span #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [DATA_W-1:0] value_i,
  output logic [CNT_W-1:0]  lanes_o
);
  logic [LANES-1:0] nz;

  for (genvar g = 0; g < LANES; g++) begin : g_nz
    assign nz[g] = |value_i[g*LANE_W +: LANE_W];
  end

  always_comb begin
    lanes_o = CNT_W'(1);
    for (int i = 1; i < LANES; i++) begin
      if (nz[i]) lanes_o = CNT_W'(i + 1);
    end
  end
endmodule

// File: rtl/emul_lane_mac.sv
// One step: acc + (mcand * lane_byte) << (lane * LANE_W), truncated.
module emul_lane_mac #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] mcand_i,
  input  logic [DATA_W-1:0] mplier_i,
  input  logic [LIDX_W-1:0] lane_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [LANE_W-1:0]        lane_val;
  logic [DATA_W+LANE_W-1:0] prod;
  logic [DATA_W-1:0]        partial;

  always_comb begin
    lane_val = LANE_W'(mplier_i >> (int'(lane_i) * LANE_W));
    prod     = mcand_i * {{DATA_W{1'b0}}, lane_val};
    partial  = DATA_W'(prod) << (int'(lane_i) * LANE_W);
    acc_o    = acc_i + partial;
  end
endmodule

// File: rtl/early_exit_mul.sv
module early_exit_mul
  import emul_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 ready_o,
  input  logic [INSN_W-1:0]    instr_i,
  input  logic [DATA_W-1:0]    rd_val_i,
  input  logic [DATA_W-1:0]    rs_val_i,
  output logic [REG_IDX_W-1:0] src_idx_o,
  output logic [DATA_W-1:0]    result_o,
  output logic [REG_IDX_W-1:0] rd_idx_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 illegal_o
);
  localparam int LANES  = DATA_W / LANE_W;
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  dec_t                 dec;
  logic [CNT_W-1:0]     span;
  logic                 busy_q, done_q, illegal_q;
  logic [DATA_W-1:0]    acc_q, acc_next, mcand_q, mplier_q;
  logic [LIDX_W-1:0]    lane_q, last_q;
  logic [REG_IDX_W-1:0] rd_q;
  logic                 accept;

  emul_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  emul_span #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_span (
    .value_i (rs_val_i),
    .lanes_o (span)
  );

  emul_lane_mac #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mac (
    .acc_i    (acc_q),
    .mcand_i  (mcand_q),
    .mplier_i (mplier_q),
    .lane_i   (lane_q),
    .acc_o    (acc_next)
  );

  assign accept = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      acc_q     <= '0;
      mcand_q   <= '0;
      mplier_q  <= '0;
      lane_q    <= '0;
      last_q    <= '0;
      rd_q      <= '0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      if (accept) begin
        if (dec.legal) begin
          busy_q   <= 1'b1;
          acc_q    <= '0;
          mcand_q  <= rd_val_i;
          mplier_q <= rs_val_i;
          lane_q   <= '0;
          last_q   <= LIDX_W'(span - CNT_W'(1));
          rd_q     <= dec.dst;
        end else begin
          illegal_q <= 1'b1;
        end
      end else if (busy_q) begin
        acc_q <= acc_next;
        if (lane_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          lane_q <= lane_q + LIDX_W'(1);
        end
      end
    end
  end

  assign ready_o   = ~busy_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign illegal_o = illegal_q;
  assign result_o  = acc_q;
  assign rd_idx_o  = rd_q;
  assign src_idx_o = dec.src;
endmodule

// File: rtl/early_exit_mul_chk.sv
module early_exit_mul_chk #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ready_o,
  input logic [15:0]       instr_i,
  input logic [DATA_W-1:0] rs_val_i,
  input logic [2:0]        rd_idx_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              illegal_o
);
  localparam int LANES = DATA_W / LANE_W;

  logic       is_mul;
  logic [3:0] lat_q, exp_q, exp_n;

  assign is_mul = (instr_i & 16'hFFC0) == 16'h4340;

  always_comb begin
    exp_n = 4'd1;
    for (int i = 1; i < LANES; i++)
      if (rs_val_i[i*LANE_W +: LANE_W] != '0) exp_n = 4'(i + 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      exp_q <= '0;
    end else if (start_i && ready_o && is_mul) begin
      lat_q <= '0;
      exp_q <= exp_n;
    end else if (busy_o) begin
      lat_q <= lat_q + 4'd1;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && ready_o));
  assert_ready_inv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o != busy_o);
  assert_busy_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && is_mul) |=> busy_o);
  assert_illegal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && !is_mul) |=> (illegal_o && !busy_o && !done_o));
  assert_illegal_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);
  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == exp_q));
  assert_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rd_idx_o));
endmodule

bind early_exit_mul early_exit_mul_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ready_o   (ready_o),
  .instr_i   (instr_i),
  .rs_val_i  (rs_val_i),
  .rd_idx_o  (rd_idx_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .illegal_o (illegal_o)
);

// File: tb/early_exit_mul_bench.sv
module early_exit_mul_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [31:0] rd_val_i = '0, rs_val_i = '0;
  logic        ready_o, busy_o, done_o, illegal_o;
  logic [2:0]  src_idx_o, rd_idx_o;
  logic [31:0] result_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  early_exit_mul u_early_exit_mul (.*);

  function automatic int exp_lat(logic [31:0] b);
    if (b[31:8] == 0) return 1;
    if (b[31:16] == 0) return 2;
    if (b[31:24] == 0) return 3;
    return 4;
  endfunction

  function automatic logic [31:0] exp_prod(logic [31:0] a, logic [31:0] b);
    logic [63:0] p = {32'd0, a} * {32'd0, b};
    return p[31:0];
  endfunction

  function automatic logic [15:0] mul_insn(logic [2:0] s, logic [2:0] d);
    return 16'h4340 | {10'd0, s, d};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Called at a negedge; returns just after the accepting edge.
  task automatic issue(logic [15:0] ins, logic [31:0] a, logic [31:0] b);
    instr_i = ins; rd_val_i = a; rs_val_i = b; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
  endtask

  // Returns at the negedge of the done cycle.
  task automatic wait_done(int exp_n, logic [31:0] exp_r, logic [2:0] exp_d, string req);
    int n = 0;
    while (n < 10) begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
      if (done_o) break;
    end
    chk({req, " R4 latency"}, 32'(n), 32'(exp_n));
    chk({req, " R3 result"}, result_o, exp_r);
    chk({req, " R3 rd_idx"}, 32'(rd_idx_o), 32'(exp_d));
    chk({req, " R6 busy low at done"}, 32'(busy_o), 32'd0);
  endtask

  task automatic run(logic [2:0] s, logic [2:0] d, logic [31:0] a, logic [31:0] b, string req);
    @(negedge clk_i);
    issue(mul_insn(s, d), a, b);
    wait_done(exp_lat(b), exp_prod(a, b), d, req);
    @(negedge clk_i);
    chk({req, " R7 done pulse"}, 32'(done_o), 32'd0);
    chk({req, " R7 result held"}, result_o, exp_prod(a, b));
  endtask

  initial begin
    forever begin
      @(posedge clk_i); cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] edges [8];
    logic [31:0] a, b;
    void'($urandom(32'd2024));
    edges = '{32'h0, 32'hFF, 32'h100, 32'hFFFF, 32'h10000, 32'hFFFFFF,
              32'h1000000, 32'hFFFFFFFF};

    repeat (3) @(negedge clk_i);
    chk("R9 busy", 32'(busy_o), 0);
    chk("R9 done", 32'(done_o), 0);
    chk("R9 illegal", 32'(illegal_o), 0);
    chk("R9 result", result_o, 0);
    chk("R9 rd_idx", 32'(rd_idx_o), 0);
    chk("R9 ready", 32'(ready_o), 1);
    rst_ni = 1'b1;

    instr_i = mul_insn(3'd5, 3'd2); #1;
    chk("R3 src_idx", 32'(src_idx_o), 32'd5);

    // R4 R5: operand edges
    foreach (edges[i]) begin
      run(3'd1, 3'(i), 32'h12345679, edges[i], "R4 rs edge");
      run(3'd2, 3'(i), edges[i], 32'h00000003, "R3 rd edge");
    end
    run(3'd0, 3'd7, 32'hFFFFFFFF, 32'h80000000, "R5 negative rs");
    run(3'd0, 3'd6, 32'd7, 32'hFFFFFFFE, "R5 minus two");

    // R1 R2: reject near-miss encodings
    begin
      logic [15:0] bad [4];
      bad = '{16'h4300, 16'h4380, 16'h4B40, 16'h0340};
      foreach (bad[i]) begin
        @(negedge clk_i);
        issue(bad[i] | 16'h0007, 32'd9, 32'd9);
        @(negedge clk_i);
        chk("R2 illegal raised", 32'(illegal_o), 1);
        chk("R2 no busy", 32'(busy_o), 0);
        chk("R2 no done", 32'(done_o), 0);
        chk("R2 result kept", result_o, exp_prod(32'd7, 32'hFFFFFFFE));
        chk("R2 rd kept", 32'(rd_idx_o), 32'd6);
        @(negedge clk_i);
        chk("R2 illegal pulse", 32'(illegal_o), 0);
      end
    end

    // R8: starts while busy are ignored
    @(negedge clk_i);
    issue(mul_insn(3'd1, 3'd3), 32'h0000_1234, 32'h1100_0000);
    chk("R6 busy after accept", 32'(busy_o), 1);
    chk("R6 ready low", 32'(ready_o), 0);
    @(negedge clk_i);
    instr_i = mul_insn(3'd2, 3'd4); rd_val_i = 32'd5; rs_val_i = 32'd6; start_i = 1'b1;
    @(negedge clk_i);
    instr_i = 16'h0000;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    chk("R8 result unchanged", result_o, exp_prod(32'h1234, 32'h1100_0000));
    chk("R8 rd unchanged", 32'(rd_idx_o), 32'd3);
    @(negedge clk_i);
    chk("R8 no second run", 32'(busy_o), 0);

    // R10: start in done cycle
    @(negedge clk_i);
    issue(mul_insn(3'd0, 3'd1), 32'd1000, 32'h0001_0203);
    wait_done(3, exp_prod(32'd1000, 32'h0001_0203), 3'd1, "R10 first");
    issue(mul_insn(3'd0, 3'd2), 32'hDEAD_BEEF, 32'h42);
    wait_done(1, exp_prod(32'hDEAD_BEEF, 32'h42), 3'd2, "R10 second");
    issue(mul_insn(3'd0, 3'd4), 32'h31, 32'hA000_0001);
    wait_done(4, exp_prod(32'h31, 32'hA000_0001), 3'd4, "R10 third");

    // random mix
    for (int k = 0; k < 60; k++) begin
      a = $urandom;
      b = $urandom >> (8 * ($urandom % 4));
      run(3'($urandom), 3'($urandom), a, b, "R3 R4 random");
    end

    summary();
  end
endmodule